// File: doc/BRIEF.md
# Stereo Serial Audio Receiver with Channel Routing

This block takes a serial audio stream (a bit clock, a left/right word clock and one data line) and turns it into 24-bit left and right samples for a DAC datapath. It accepts four framings: right-justified, left-justified, I2S and a pulse-marked frame-sync layout. It accepts 16, 20, 24 or 32-bit words. Every received word is brought to 24 bits. Shorter words get zeros appended below their LSB, and longer words lose their low-order bits.

A phase control decides which word-clock level carries the right channel. In frame-sync layout the same bit instead selects the MSB delay. A separate swap control exchanges the two channels at the output. The bit clock can be interpreted inverted. In master mode the block generates the bit clock and word clock itself from fixed dividers. The outputs update once per frame, together with a one-cycle strobe. The two samples in a pair always come from the same frame.

Configuration is expected to be static while the block runs. Change it only while reset is held.

Top module: `audio_rx`

## Requirements
- R1: Right-justified (`fmt`=00) and left-justified (`fmt`=01) layouts.
  - With `phase`=0, the right word is sent while the word clock is low. With `phase`=1, it is sent while the word clock is high.
  - Left-justified words start MSB first on the first bit-clock rise after a word-clock change.
  - Right-justified words end with their LSB on the last rise before the change.
- R2: I2S layout (`fmt`=10). The MSB arrives on the second rise after a word-clock change. The level sense is inverted against R1: with `phase`=0 the right word is sent while the word clock is high.
- R3: Frame-sync layout (`fmt`=11).
  - A rising word clock marks the frame. The left word comes first and the right word follows at once.
  - With `phase`=0 the left MSB is taken on the rise that first sees the word clock high. With `phase`=1 it is taken on the next rise.
- R4: Word length `wlen` selects the received word size: 00 is 16 bits, 01 is 20, 10 is 24 and 11 is 32.
  - A 16-bit word W appears as {W, 8'h00}.
  - A 20-bit word appears as {W, 4'h0}.
  - A 24-bit word is passed unchanged.
  - A 32-bit word gives W[31:8].
- R5: Right-justified layout with `wlen`=11 is received as a 24-bit word.
- R6: `swap`=0 routes the word received as left to `left_out`. `swap`=1 routes it to `right_out`, and routes the word received as right to `left_out`.
- R7: The output samples change only in a cycle where `valid` is high. `valid` is high for single cycles. Each pulse presents the left and right words of one frame. A right word received without a preceding left word of its frame is dropped.
- R8: `bclk_inv`=1 makes the block treat the opposite bit-clock edge as the sampling (rising) edge.
- R9: Master mode (`master`=1).
  - `bclk_out` has a period of 2*BCLK_DIV clock cycles.
  - `lrclk_out` changes only when the interpreted bit clock falls.
  - In the justified and I2S layouts, `lrclk_out` holds each level for HALF_BITS bit-clock periods.
  - In slave mode both outputs stay low.
- R10: In reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Layout select: 00 right-justified, 01 left-justified, 10 I2S, 11 frame-sync |
| wlen | input | 2 | Word length: 00 16, 01 20, 10 24, 11 32 bits |
| phase | input | 1 | Channel level sense, or MSB delay in frame-sync layout |
| swap | input | 1 | Exchange the output channels |
| master | input | 1 | 1 generates the clocks, 0 uses bclk_in and lrclk_in |
| bclk_inv | input | 1 | Interpret the bit clock inverted |
| bclk_in | input | 1 | Bit clock in slave mode |
| lrclk_in | input | 1 | Word clock in slave mode |
| sdata_in | input | 1 | Serial data |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| lrclk_out | output | 1 | Generated word clock (master mode) |
| left_out | output | 24 | Left sample |
| right_out | output | 24 | Right sample |
| valid | output | 1 | One-cycle strobe on a new sample pair |

## Verification
A reference serializer in the bench drives every layout at each word length, with both phase settings, both swap settings and both bit-clock senses. For each run, two consecutive received pairs must match the transmitted frames.

Each corner case maps to a specific kind of design error:
- A one-bit alignment error in I2S or frame-sync mode shifts every sample by a factor of two.
- A wrong level sense produces pairs taken from two different frames.
- A missing right-justified 32-to-24 rule returns the wrong bits.
- Swapped zero padding or truncation corrupts the low byte or the high byte.

In master mode the bench measures the bit-clock period and the word-clock half length, and checks that the word clock moves only on falling interpreted edges. A generator that moved it on the sampling edge would race its own data.

// File: rtl/audio_rx.sv
module audio_rx #(
  parameter int BCLK_DIV  = 2,
  parameter int HALF_BITS = 36
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  fmt,
  input  logic [1:0]  wlen,
  input  logic        phase,
  input  logic        swap,
  input  logic        master,
  input  logic        bclk_inv,
  input  logic        bclk_in,
  input  logic        lrclk_in,
  input  logic        sdata_in,
  output logic        bclk_out,
  output logic        lrclk_out,
  output logic [23:0] left_out,
  output logic [23:0] right_out,
  output logic        valid
);

  localparam logic [1:0] F_RJ = 2'd0, F_LJ = 2'd1, F_I2S = 2'd2, F_FS = 2'd3;
  localparam int DW = (BCLK_DIV > 1) ? $clog2(BCLK_DIV) : 1;
  localparam int BW = $clog2(2 * HALF_BITS + 1);
  localparam int CW = 7;

  // clock generator for master mode
  logic [DW-1:0] dcnt;
  logic          gen_b;
  logic [BW-1:0] bitc, bitc_nx;

  wire tick     = (dcnt == DW'(BCLK_DIV - 1));
  wire gen_fall = tick && (gen_b ^ bclk_inv);
  assign bitc_nx  = (bitc == BW'(2 * HALF_BITS - 1)) ? '0 : bitc + 1'b1;
  assign bclk_out = gen_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0; gen_b <= 1'b0; bitc <= '0; lrclk_out <= 1'b0;
    end else if (!master) begin
      dcnt <= '0; gen_b <= 1'b0; bitc <= '0; lrclk_out <= 1'b0;
    end else begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (tick) gen_b <= ~gen_b;
      if (gen_fall) begin
        bitc      <= bitc_nx;
        lrclk_out <= (fmt == F_FS) ? (bitc_nx == '0) : (bitc_nx >= BW'(HALF_BITS));
      end
    end
  end

  // receive path
  wire bl = (master ? gen_b : bclk_in) ^ bclk_inv;
  wire lr = master ? lrclk_out : lrclk_in;

  logic          bl_q, lr_q, have_l;
  logic [31:0]   sr, word;
  logic [CW-1:0] cnt, cnt_cur, nbits, endl, endr;
  logic [1:0]    wl_eff;
  logic [23:0]   l_hold, sized;
  logic          cap_l, cap_r, ch_r;

  wire        rise     = bl & ~bl_q;
  wire        edge_any = lr ^ lr_q;
  wire        mark     = (fmt == F_FS) ? (lr & ~lr_q) : edge_any;
  wire [31:0] sr_nx    = {sr[30:0], sdata_in};
  wire [CW-1:0] dly    = (fmt == F_I2S) ? CW'(1) : (fmt == F_FS) ? CW'(phase) : '0;

  assign wl_eff  = (fmt == F_RJ && wlen == 2'd3) ? 2'd2 : wlen;
  assign cnt_cur = mark ? '0 : (&cnt ? cnt : cnt + 1'b1);
  assign endl    = dly + nbits - 1'b1;
  assign endr    = endl + nbits;

  always_comb begin
    case (wl_eff)
      2'd0:    begin nbits = CW'(16); sized = {word[15:0], 8'h00}; end
      2'd1:    begin nbits = CW'(20); sized = {word[19:0], 4'h0};  end
      2'd2:    begin nbits = CW'(24); sized = word[23:0];          end
      default: begin nbits = CW'(32); sized = word[31:8];          end
    endcase
  end

  always_comb begin
    cap_l = 1'b0;
    cap_r = 1'b0;
    ch_r  = 1'b0;
    word  = sr_nx;
    case (fmt)
      F_RJ: begin
        word = sr;
        ch_r = lr_q ^ ~phase;
        if (edge_any) begin cap_l = ~ch_r; cap_r = ch_r; end
      end
      F_FS: begin
        cap_l = (cnt_cur == endl);
        cap_r = (cnt_cur == endr);
      end
      default: begin
        ch_r = (fmt == F_I2S) ? (lr ^ phase) : (lr ^ ~phase);
        if (cnt_cur == endl) begin cap_l = ~ch_r; cap_r = ch_r; end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_q <= 1'b0; lr_q <= 1'b0; sr <= '0; cnt <= '1; have_l <= 1'b0;
      l_hold <= '0; left_out <= '0; right_out <= '0; valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      bl_q  <= bl;
      if (rise) begin
        lr_q <= lr;
        sr   <= sr_nx;
        cnt  <= cnt_cur;
        if (cap_l) begin
          l_hold <= sized;
          have_l <= 1'b1;
        end else if (cap_r) begin
          if (have_l) begin
            left_out  <= swap ? sized : l_hold;
            right_out <= swap ? l_hold : sized;
            valid     <= 1'b1;
          end
          have_l <= 1'b0;
        end
      end
    end
  end

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(left_out) && $stable(right_out)));

  assert_pad16_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && wlen == 2'd0) |-> (left_out[7:0] == 8'h00 && right_out[7:0] == 8'h00));

  assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> (!bclk_out && !lrclk_out));

  assert_lr_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $changed(lrclk_out)) |-> (((gen_b ^ bclk_inv) == 1'b0) && $changed(gen_b)));

endmodule

// File: tb/audio_rx_tb.sv
module audio_rx_tb;
  localparam int BCLK_DIV = 2;
  localparam int HB = 36;
  localparam int BH = 2;
  localparam int NV = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fmt = 2'd1, wlen = 2'd2;
  logic phase = 0, swap = 0, master = 0, bclk_inv = 0;
  logic bclk_in = 0, lrclk_in = 0, sdata_in = 0;
  logic bclk_out, lrclk_out, valid;
  logic [23:0] left_out, right_out;

  int checks = 0, fails = 0, nrx = 0, vlong = 0;
  logic [23:0] rxl [16];
  logic [23:0] rxr [16];
  logic vprev = 0;

  always #2.5 clk = ~clk;

  audio_rx #(.BCLK_DIV(BCLK_DIV), .HALF_BITS(HB)) u_dut (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .wlen(wlen), .phase(phase), .swap(swap),
    .master(master), .bclk_inv(bclk_inv), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
    .sdata_in(sdata_in), .bclk_out(bclk_out), .lrclk_out(lrclk_out),
    .left_out(left_out), .right_out(right_out), .valid(valid));

  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (nrx < 16) begin rxl[nrx] = left_out; rxr[nrx] = right_out; end
      nrx++;
      if (vprev) vlong++;
    end
    vprev = rst_n && valid;
  end

  // {fmt, wlen, phase, swap, inv, left32, right32}
  localparam logic [70:0] VEC [NV] = '{
    {2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 32'h00A5C3F1, 32'h005A3C0E},
    {2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 32'h00008001, 32'h00007FFE},
    {2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 32'h000C0FFE, 32'h00081234},
    {2'd1, 2'd3, 1'b1, 1'b1, 1'b0, 32'h89ABCDEF, 32'h13579BDF},
    {2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 32'h00800001, 32'h007FFFFE},
    {2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0000C001, 32'h00003FF3},
    {2'd2, 2'd3, 1'b0, 1'b0, 1'b1, 32'hF00000FF, 32'h0FEDCB01},
    {2'd2, 2'd1, 1'b1, 1'b0, 1'b1, 32'h000A5A5A, 32'h00050505},
    {2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000B00B, 32'h00001EE1},
    {2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 32'h00C0FFEE, 32'h00123456},
    {2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 32'hFFABCDEF, 32'hEE765432},
    {2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 32'h0008F00D, 32'h0007ABCD},
    {2'd3, 2'd2, 1'b0, 1'b0, 1'b0, 32'h00D1E2F3, 32'h00102030},
    {2'd3, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0000F0F1, 32'h00000F0E},
    {2'd3, 2'd3, 1'b1, 1'b0, 1'b1, 32'hCAFEF00D, 32'h31415926},
    {2'd3, 2'd1, 1'b0, 1'b1, 1'b0, 32'h000ABCDE, 32'h00054321}
  };

  function automatic int nbits_of(logic [1:0] f, logic [1:0] w);
    case (w)
      2'd0: return 16;
      2'd1: return 20;
      2'd2: return 24;
      default: return (f == 2'd0) ? 24 : 32; // R5
    endcase
  endfunction

  function automatic logic [23:0] exp24(logic [31:0] d, logic [1:0] f, logic [1:0] w);
    int n;
    logic [31:0] m;
    n = nbits_of(f, w);
    m = (n == 32) ? d : (d & ((32'h1 << n) - 1));
    case (n)
      16: return {m[15:0], 8'h00};
      20: return {m[19:0], 4'h0};
      24: return m[23:0];
      default: return m[31:8];
    endcase
  endfunction

  // reference serializer: one frame of 2*HB bit-clock periods
  task automatic send_frame(input logic [31:0] l, input logic [31:0] r);
    int n;
    logic lvl_left;
    n = nbits_of(fmt, wlen);
    lvl_left = (fmt == 2'd2) ? phase : ~phase;
    for (int k = 0; k < 2 * HB; k++) begin
      int j, idx;
      logic lrv, sdv;
      logic [31:0] wd;
      j = k % HB;
      wd = (k < HB) ? l : r;
      sdv = 1'b0;
      if (fmt == 2'd3) begin
        lrv = (k == 0);
        idx = k - int'(phase);
        if (idx >= 0 && idx < n) sdv = l[n - 1 - idx];
        else if (idx >= n && idx < 2 * n) sdv = r[2 * n - 1 - idx];
      end else begin
        lrv = (k < HB) ? lvl_left : ~lvl_left;
        if (fmt == 2'd1 && j < n) sdv = wd[n - 1 - j];
        if (fmt == 2'd2 && j >= 1 && j <= n) sdv = wd[n - j];
        if (fmt == 2'd0 && j >= HB - n) sdv = wd[HB - 1 - j];
      end
      bclk_in = bclk_inv; lrclk_in = lrv; sdata_in = sdv;
      repeat (BH) @(negedge clk);
      bclk_in = ~bclk_inv;
      repeat (BH) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bclk_in = bclk_inv; lrclk_in = 1'b0; sdata_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nrx = 0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic master_run(input logic inv);
    int t, rise1, rise2, nb, lastb, toggles, bad_phase, bad_half;
    logic pb, pl;
    master = 1'b1; bclk_inv = inv; fmt = 2'd1; wlen = 2'd2; phase = 1'b0; swap = 1'b0;
    @(negedge clk); rst_n = 1'b0; sdata_in = 1'b1;
    repeat (2) @(negedge clk);
    // R10 reset state
    check(!valid && left_out == 0 && right_out == 0, "R10", "reset outputs",
          {23'd0, valid, left_out}, 48'd0);
    check(!bclk_out && !lrclk_out, "R9", "master clocks low in reset",
          {46'd0, bclk_out, lrclk_out}, 48'd0);
    rst_n = 1'b1; nrx = 0;
    rise1 = -1; rise2 = -1; nb = 0; lastb = -1; toggles = 0; bad_phase = 0; bad_half = 0;
    pb = bclk_out; pl = lrclk_out;
    for (t = 0; t < 1200; t++) begin
      @(negedge clk);
      if (bclk_out && !pb) begin
        if (rise1 < 0) rise1 = t; else if (rise2 < 0) rise2 = t;
        nb++;
      end
      if (lrclk_out != pl) begin
        if (((pb ^ inv) != 1'b1) || ((bclk_out ^ inv) != 1'b0)) bad_phase++;
        if (lastb >= 0 && (nb - lastb) != HB) bad_half++;
        lastb = nb; toggles++;
      end
      pb = bclk_out; pl = lrclk_out;
    end
    check(rise2 - rise1 == 2 * BCLK_DIV, "R9", "bclk_out period",
          48'(rise2 - rise1), 48'(2 * BCLK_DIV));
    check(toggles >= 3 && bad_half == 0, "R9", "lrclk_out half length",
          48'(bad_half), 48'd0);
    check(bad_phase == 0, "R9", "lrclk_out moves on falling interpreted edge",
          48'(bad_phase), 48'd0);
    check(nrx >= 2 && rxl[1] == 24'hFFFFFF && rxr[1] == 24'hFFFFFF, "R9",
          "master-mode capture", {rxl[1], rxr[1]}, {24'hFFFFFF, 24'hFFFFFF});
    master = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R10: outputs low in reset (slave)
    check(!valid && left_out == 0 && right_out == 0 && !bclk_out && !lrclk_out,
          "R10", "reset state", {21'd0, valid, bclk_out, lrclk_out, left_out}, 48'd0);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] bl0, br0, fl [4], fr [4];
      logic [23:0] e1l, e1r, e2l, e2r;
      bit found;
      string req;
      {fmt, wlen, phase, swap, bclk_inv, bl0, br0} = VEC[v];
      master = 1'b0;
      do_reset();
      for (int i = 0; i < 4; i++) begin
        fl[i] = bl0 + 32'(i) * 32'h01020305;
        fr[i] = br0 ^ (32'(i) * 32'h10203041);
        send_frame(fl[i], fr[i]);
      end
      repeat (4) @(negedge clk);
      e1l = swap ? exp24(fr[1], fmt, wlen) : exp24(fl[1], fmt, wlen);
      e1r = swap ? exp24(fl[1], fmt, wlen) : exp24(fr[1], fmt, wlen);
      e2l = swap ? exp24(fr[2], fmt, wlen) : exp24(fl[2], fmt, wlen);
      e2r = swap ? exp24(fl[2], fmt, wlen) : exp24(fr[2], fmt, wlen);
      found = 0;
      for (int i = 0; i + 1 < nrx && i + 1 < 16; i++)
        if (rxl[i] == e1l && rxr[i] == e1r && rxl[i+1] == e2l && rxr[i+1] == e2r) found = 1;
      // tags: R1 justified, R2 I2S, R3 frame-sync, R5 RJ 32-bit; all cover R4 R6 R8
      req = (fmt == 2'd0 && wlen == 2'd3) ? "R5" : (fmt == 2'd2) ? "R2" :
            (fmt == 2'd3) ? "R3" : "R1";
      check(found, req, $sformatf("vector %0d pair (R4 R6 R8)", v),
            {rxl[(nrx > 2) ? 1 : 0], rxr[(nrx > 2) ? 1 : 0]}, {e1l, e1r});
    end

    check(vlong == 0, "R7", "valid pulses one cycle", 48'(vlong), 48'd0);

    master_run(1'b0);
    master_run(1'b1);
    check(vlong == 0, "R7", "valid single cycle in master mode", 48'(vlong), 48'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule